// File: doc/BRIEF.md
# Programmable Pulse-Width Modulator with Shadowed Period

This block is a single-channel PWM source that software sets up through two 32-bit words: a control word and a period word. A prescaler divides the clock into counting ticks. A bypass bit can skip the prescaler. A period counter steps on each tick and wraps after the programmed total. The single output sits at its active level while the counter is below the programmed active count. A polarity bit decides whether the active level is high or low.

Two modes are offered. Cycle mode repeats the period without end. Pulse mode emits one period each time software sets the start bit. The start bit clears itself when that period ends.

While the channel runs, a new period word is held in a shadow copy. It takes effect only at the next period wrap, and a busy flag tells software that the copy is still pending. When the channel is idle, a period write takes effect at once.

Top module: `pwm_timer`

## Requirements
- R1: The control word at byte address 0x0 holds the prescale code in bits [3:0], enable in bit 4, polarity in bit 5 (1 = active high), gate in bit 6, mode in bit 7 (1 = pulse, 0 = cycle), start in bit 8 and prescaler bypass in bit 9. Bit 28 is the read-only busy flag. All other bits, and any other address, read as zero.
- R2: The period word at byte address 0x4 holds the total tick count in bits [31:16] and the active tick count in bits [15:0]. It reads back the value last written.
- R3: After reset both words read zero, busy is clear, and the output is at its inactive level. With polarity 0 that level is 1.
- R4: The channel runs only while enable and gate are both set. Otherwise the output is held at the inactive level. On each restart the counter begins again at zero, in the active phase.
- R5: Code 0xF or a set bypass bit gives one tick per clock. A code k below PRESC_CODES gives one tick per PRESC_BASE<<k clocks. Any other code, with bypass clear, holds the output inactive.
- R6: A period lasts max(total,1) ticks. The output is active while the tick count inside the period is below the active count, so an active count at or above the total gives a constant active level.
- R7: The active level is high when polarity is 1 and low when polarity is 0, and the inactive level is its complement.
- R8: A period write while running sets busy from the next cycle. The old period continues until its wrap, and then the new values apply and busy clears.
- R9: A period write while not running applies at once and leaves busy clear. A channel that stops with busy set clears it on the next cycle.
- R10: In pulse mode, setting start gives exactly one period, active phase first. Then start reads 0 and the output returns to inactive.
- R11: In pulse mode with start clear, the output stays inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| pwmOut | output | 1 | PWM output |

## Verification
A counter or prescaler that goes wrong shows up on pwmOut within one period: the phase boundary or the wrap moves by at least one tick. A shadow copy that fires at the wrong moment shows up in two ways. The period length changes before the wrap in progress has ended, or the busy flag in the control word does not drop in the cycle right after that wrap. A stale start bit shows in pulse mode as a second active phase, or as a start bit that still reads 1 one cycle after the pulse ends.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  timeunit 1ns; timeprecision 100ps;

  parameter int unsigned CNT_W = 16;
  parameter int unsigned REG_W = 32;

  localparam int unsigned BIT_EN    = 4;
  localparam int unsigned BIT_POL   = 5;
  localparam int unsigned BIT_GATE  = 6;
  localparam int unsigned BIT_MODE  = 7;
  localparam int unsigned BIT_START = 8;
  localparam int unsigned BIT_BYP   = 9;
  localparam int unsigned BIT_BUSY  = 28;
  localparam logic [3:0]  CODE_DIRECT = 4'hF;

  // Strobes and settings handed from the control side to the datapath
  typedef struct packed {
    logic             run;
    logic             activeHigh;
    logic             bypass;
    logic [3:0]       prescCode;
    logic [CNT_W-1:0] totalCnt;
    logic [CNT_W-1:0] activeCnt;
  } pwmCmd_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned PRESC_CODES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              wrap,
  output pwmCmd_t           cmd,
  output logic              busy,
  output logic              startBit,
  output logic              pulseMode
);
  timeunit 1ns; timeprecision 100ps;

  logic [3:0]       prescCodeQ;
  logic             enQ, polQ, gateQ, pulseQ, startQ, bypassQ, busyQ;
  logic [CNT_W-1:0] shadowTot, shadowAct, workTot, workAct;

  logic selCtrl, selPer, wrCtrl, wrPer, armNow, newArm, runNow;

  function automatic logic codeOk(input logic [3:0] code, input logic byp);
    return byp || (code == CODE_DIRECT) || (int'(code) < int'(PRESC_CODES));
  endfunction

  assign selCtrl = (regAddr == ADDR_W'(0));
  assign selPer  = (regAddr == ADDR_W'(4));
  assign wrCtrl  = regWrEn && selCtrl;
  assign wrPer   = regWrEn && selPer;

  assign armNow = enQ && gateQ && codeOk(prescCodeQ, bypassQ);
  assign runNow = armNow && (pulseQ ? startQ : 1'b1);
  assign newArm = regWrData[BIT_EN] && regWrData[BIT_GATE] && regWrData[BIT_MODE]
                  && codeOk(regWrData[3:0], regWrData[BIT_BYP]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCodeQ <= '0;
      enQ        <= 1'b0;
      polQ       <= 1'b0;
      gateQ      <= 1'b0;
      pulseQ     <= 1'b0;
      startQ     <= 1'b0;
      bypassQ    <= 1'b0;
    end else if (wrCtrl) begin
      prescCodeQ <= regWrData[3:0];
      enQ        <= regWrData[BIT_EN];
      polQ       <= regWrData[BIT_POL];
      gateQ      <= regWrData[BIT_GATE];
      pulseQ     <= regWrData[BIT_MODE];
      bypassQ    <= regWrData[BIT_BYP];
      startQ     <= ((startQ && !(wrap && pulseQ)) || regWrData[BIT_START]) && newArm;
    end else if ((wrap && pulseQ) || !armNow || !pulseQ) begin
      startQ     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowTot <= '0;
      shadowAct <= '0;
      workTot   <= '0;
      workAct   <= '0;
      busyQ     <= 1'b0;
    end else if (wrPer) begin
      shadowTot <= regWrData[REG_W-1 -: CNT_W];
      shadowAct <= regWrData[CNT_W-1:0];
      if (runNow) begin
        busyQ <= 1'b1;
        if (wrap && busyQ) begin
          workTot <= shadowTot;
          workAct <= shadowAct;
        end
      end else begin
        workTot <= regWrData[REG_W-1 -: CNT_W];
        workAct <= regWrData[CNT_W-1:0];
        busyQ   <= 1'b0;
      end
    end else if (busyQ && (wrap || !runNow)) begin
      workTot <= shadowTot;
      workAct <= shadowAct;
      busyQ   <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (selCtrl) begin
      regRdData[3:0]       = prescCodeQ;
      regRdData[BIT_EN]    = enQ;
      regRdData[BIT_POL]   = polQ;
      regRdData[BIT_GATE]  = gateQ;
      regRdData[BIT_MODE]  = pulseQ;
      regRdData[BIT_START] = startQ;
      regRdData[BIT_BYP]   = bypassQ;
      regRdData[BIT_BUSY]  = busyQ;
    end else if (selPer) begin
      regRdData = {shadowTot, shadowAct};
    end
  end

  always_comb begin
    cmd.run        = runNow;
    cmd.activeHigh = polQ;
    cmd.bypass     = bypassQ;
    cmd.prescCode  = prescCodeQ;
    cmd.totalCnt   = workTot;
    cmd.activeCnt  = workAct;
  end

  assign busy      = busyQ;
  assign startBit  = startQ;
  assign pulseMode = pulseQ;
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int unsigned PRESC_BASE  = 2,
  parameter int unsigned PRESC_CODES = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  pwmCmd_t cmd,
  output logic    wrap,
  output logic    pwmOut
);
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned MAX_RATIO = PRESC_BASE << (PRESC_CODES - 1);
  localparam int unsigned PC_W      = $clog2(MAX_RATIO + 1);

  logic [PC_W-1:0]  ratioTab [16];
  logic [PC_W-1:0]  ratio, pcQ;
  logic [CNT_W-1:0] cntQ;
  logic             tick, endOfPer, activePhase;

  for (genvar k = 0; k < 16; k++) begin : gRatio
    if (k == 15) begin : gDirect
      assign ratioTab[k] = PC_W'(1);
    end else if (k < PRESC_CODES) begin : gDiv
      assign ratioTab[k] = PC_W'(PRESC_BASE << k);
    end else begin : gUnused
      assign ratioTab[k] = PC_W'(1);
    end
  end

  assign ratio    = cmd.bypass ? PC_W'(1) : ratioTab[cmd.prescCode];
  assign tick     = cmd.run && (pcQ >= ratio - PC_W'(1));
  assign endOfPer = ({1'b0, cntQ} + (CNT_W+1)'(1)) >= {1'b0, cmd.totalCnt};
  assign wrap     = tick && endOfPer;

  always_ff @(posedge clk) begin
    if (!rstN || !cmd.run) begin
      pcQ  <= '0;
      cntQ <= '0;
    end else if (tick) begin
      pcQ  <= '0;
      cntQ <= endOfPer ? '0 : cntQ + CNT_W'(1);
    end else begin
      pcQ  <= pcQ + PC_W'(1);
    end
  end

  assign activePhase = cntQ < cmd.activeCnt;
  assign pwmOut      = (cmd.run && activePhase) ? cmd.activeHigh : !cmd.activeHigh;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned PRESC_BASE  = 2,
  parameter int unsigned PRESC_CODES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              pwmOut
);
  timeunit 1ns; timeprecision 100ps;

  pwmCmd_t cmd;
  logic    wrap, busy, startQ, pulseMode;

  pwm_ctrl #(.ADDR_W(ADDR_W), .PRESC_CODES(PRESC_CODES)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .wrap(wrap), .cmd(cmd),
    .busy(busy), .startBit(startQ), .pulseMode(pulseMode)
  );

  pwm_datapath #(.PRESC_BASE(PRESC_BASE), .PRESC_CODES(PRESC_CODES)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrap(wrap), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              pwmOut,
  input logic              run,
  input logic              activeHigh,
  input logic              wrap,
  input logic              busy,
  input logic              startBit,
  input logic              pulseMode
);
  timeunit 1ns; timeprecision 100ps;

  logic perWr, ctrlWr;
  assign perWr  = regWrEn && (regAddr == ADDR_W'(4));
  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(0));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (pwmOut == !activeHigh));

  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && perWr) |=> busy);

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrap && !perWr) |=> !busy);

  // R9
  idle_nobusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !busy);

  // R10
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseMode && wrap && !ctrlWr) |=> !startBit);
endmodule

bind pwm_timer pwm_timer_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .pwmOut(pwmOut),
  .run(cmd.run), .activeHigh(cmd.activeHigh), .wrap(wrap), .busy(busy),
  .startBit(startQ), .pulseMode(pulseMode)
);

// File: tb/sim_pwm_timer.sv
module sim_pwm_timer;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pwmOut;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;

  pwm_timer u0 (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
                .regWrData(regWrData), .regRdData(regRdData), .pwmOut(pwmOut));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
  endtask

  task automatic readCheck(input string tag, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a; #1;
    check(tag, regRdData, exp);
    regAddr = '0;
  endtask

  function automatic logic expOut(input int k, input int tot, input int act,
                                  input int ratio, input logic pol);
    int per = (tot == 0) ? 1 : tot;
    return (((k / ratio) % per) < act) ? pol : !pol;
  endfunction

  function automatic logic [31:0] ctrlWord(input logic [3:0] code, input logic pol,
                                           input logic byp);
    return {22'd0, byp, 1'b0, 1'b0, 1'b1, pol, 1'b1, code};
  endfunction

  task automatic sweep(input logic [3:0] code, input logic byp, input int ratio,
                       input logic pol, input int tot, input int act);
    int per = (tot == 0) ? 1 : tot;
    writeReg(4'h0, 32'h0);
    writeReg(4'h4, {tot[15:0], act[15:0]});
    readCheck("R9 idle period write leaves busy clear", 4'h0, 32'h0);
    writeReg(4'h0, ctrlWord(code, pol, byp));
    for (int k = 0; k < 3 * per * ratio; k++) begin
      check("R5 R6 R7 cycle waveform", {31'd0, pwmOut}, {31'd0, expOut(k, tot, act, ratio, pol)});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int tots[6] = '{5, 4, 3, 3, 0, 2};
    int acts[6] = '{2, 0, 3, 7, 0, 1};
    logic [3:0] codes[4] = '{4'hF, 4'h0, 4'h1, 4'h5};
    logic bypS[4] = '{1'b0, 1'b0, 1'b0, 1'b1};
    int ratios[4] = '{1, 2, 4, 1};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3 reset state
    check("R3 output inactive after reset", {31'd0, pwmOut}, 32'd1);
    readCheck("R3 control after reset", 4'h0, 32'h0);
    readCheck("R3 period after reset", 4'h4, 32'h0);

    // R2 period layout and readback
    writeReg(4'h4, 32'h0005_0002);
    readCheck("R2 period readback", 4'h4, 32'h0005_0002);
    readCheck("R9 busy clear after idle write", 4'h0, 32'h0);

    // R1 field layout, read-only busy, reserved bits
    writeReg(4'h0, 32'hFFFF_FFFF);
    readCheck("R1 control readback all ones", 4'h0, 32'h0000_03FF);
    writeReg(4'h0, 32'h0);
    writeReg(4'h0, 32'hEFFF_FC00);
    readCheck("R1 reserved bits read zero", 4'h0, 32'h0);
    readCheck("R1 unmapped address reads zero", 4'h8, 32'h0);
    readCheck("R1 misaligned address reads zero", 4'h2, 32'h0);

    // R5 R6 R7 sweep of prescale, polarity and period shapes
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 6; s++)
          sweep(codes[c], bypS[c], ratios[c], p[0], tots[s], acts[s]);

    // R4 enable alone, gate alone
    writeReg(4'h0, 32'h0);
    writeReg(4'h4, 32'h0004_0002);
    writeReg(4'h0, 32'h0000_003F);
    for (int k = 0; k < 12; k++) begin
      check("R4 enable without gate holds inactive", {31'd0, pwmOut}, 32'd0);
      @(negedge clk);
    end
    writeReg(4'h0, 32'h0000_006F);
    for (int k = 0; k < 12; k++) begin
      check("R4 gate without enable holds inactive", {31'd0, pwmOut}, 32'd0);
      @(negedge clk);
    end
    writeReg(4'h0, 32'h0000_007F);
    repeat (3) @(negedge clk);
    writeReg(4'h0, 32'h0000_003F);
    check("R4 clearing gate stops output", {31'd0, pwmOut}, 32'd0);
    writeReg(4'h0, 32'h0000_007F);
    for (int k = 0; k < 8; k++) begin
      check("R4 restart begins at count zero", {31'd0, pwmOut}, {31'd0, expOut(k, 4, 2, 1, 1'b1)});
      @(negedge clk);
    end

    // R5 unused codes hold inactive; bypass overrides them
    writeReg(4'h0, 32'h0);
    writeReg(4'h0, 32'h0000_007A);
    for (int k = 0; k < 10; k++) begin
      check("R5 unused code 0xA holds inactive", {31'd0, pwmOut}, 32'd0);
      @(negedge clk);
    end
    writeReg(4'h0, 32'h0000_0078);
    for (int k = 0; k < 10; k++) begin
      check("R5 unused code 0x8 holds inactive", {31'd0, pwmOut}, 32'd0);
      @(negedge clk);
    end
    writeReg(4'h0, 32'h0);
    writeReg(4'h0, 32'h0000_027A);
    for (int k = 0; k < 8; k++) begin
      check("R5 bypass with unused code runs undivided", {31'd0, pwmOut}, {31'd0, expOut(k, 4, 2, 1, 1'b1)});
      @(negedge clk);
    end

    // R8 shadowed period update while running
    writeReg(4'h0, 32'h0);
    writeReg(4'h4, 32'h0004_0001);
    writeReg(4'h0, 32'h0000_007F);
    check("R8 cycle 0 old period", {31'd0, pwmOut}, 32'd1);
    regAddr = 4'h4; regWrData = 32'h0006_0003; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 4'h0; regWrData = '0;
    #1;
    check("R8 busy set after running write", {31'd0, regRdData[28]}, 32'd1);
    check("R8 old period continues", {31'd0, pwmOut}, 32'd0);
    for (int k = 2; k < 22; k++) begin
      @(negedge clk);
      #1;
      check("R8 busy until wrap", {31'd0, regRdData[28]}, {31'd0, k < 4});
      check("R8 waveform across update", {31'd0, pwmOut},
            {31'd0, (k < 4) ? expOut(k, 4, 1, 1, 1'b1) : expOut(k - 4, 6, 3, 1, 1'b1)});
    end

    // R10 one-shot pulse, then re-trigger
    writeReg(4'h0, 32'h0);
    writeReg(4'h4, 32'h0003_0001);
    for (int rep = 0; rep < 2; rep++) begin
      writeReg(4'h0, 32'h0000_01F0);
      for (int k = 0; k < 16; k++) begin
        #1;
        check("R10 pulse waveform", {31'd0, pwmOut},
              {31'd0, (k < 6) ? expOut(k, 3, 1, 2, 1'b1) : 1'b0});
        check("R10 start bit self clears", {31'd0, regRdData[8]}, {31'd0, k < 6});
        @(negedge clk);
      end
    end

    // R11 pulse mode without start
    writeReg(4'h0, 32'h0000_00F0);
    for (int k = 0; k < 12; k++) begin
      check("R11 pulse mode idle without start", {31'd0, pwmOut}, 32'd0);
      @(negedge clk);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule